// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block turns two control pins into one of three operating modes for a dual converter core. A power-down select input and a converter enable input are sampled on the clock and decoded into run, standby or shutdown. From the mode the block drives an enable for the reference and control-amplifier section, an enable for the current array, and an output-mode code. The output-mode code tells the analog edge whether to drive the code, float, or clamp to ground.

Leaving a low-power mode is timed. A down-counter is loaded on every mode change, and `ready_o` stays low until the counter has drained. Exit from shutdown uses a long delay and exit from standby uses a short one, because in standby the reference never stopped.

The block also keeps the converter code. It captures the input code only while ready is high. The captured value therefore survives standby and shutdown, and it is presented again when the converter wakes up.

Top module: `cvt_pwr_ctrl`

## Requirements
- R1: With `pd_i` high at a rising edge, the next cycle shows shutdown: `ref_en_o`=0, `array_en_o`=0 and `ready_o`=0, whatever `en_i` is.
- R2: With `pd_i` low and `en_i` low at a rising edge, the next cycle shows standby: `ref_en_o`=1, `array_en_o`=0 and `ready_o`=0.
- R3: With `pd_i` low and `en_i` high at a rising edge, the next cycle shows run: `ref_en_o`=1, `array_en_o`=1 and `out_mode_o`=2'b00 (drive).
- R4: In standby and shutdown, `out_mode_o` is 2'b01 (float) when `OFF_GROUND`=0, and 2'b10 (clamp to ground) when `OFF_GROUND`=1.
- R5: The pins are registered once, so a pin change shows at the outputs after exactly one rising edge.
- R6: On entry to run from shutdown, `ready_o` stays low for `SHUT_CYC` cycles counted from the first run cycle, then goes high.
- R7: On entry to run from standby, `ready_o` stays low for `STBY_CYC` cycles counted from the first run cycle, then goes high.
- R8: Every mode change restarts the settle counter, and the delay is chosen by the mode just left. Toggling `en_i` while `pd_i` is high is not a mode change and has no effect.
- R9: `code_o` loads `code_i` at each rising edge where `ready_o` is high, and holds its value at every other edge. The last run code is therefore presented again after wake-up.
- R10: Reset (`rst_n` low, asynchronous) gives shutdown with `ready_o`=0 and `code_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down select; high forces shutdown |
| en_i | input | 1 | Converter enable; picks run or standby when `pd_i` is low |
| code_i | input | CODE_W | Converter code |
| ref_en_o | output | 1 | Enable for the reference and control amplifier |
| array_en_o | output | 1 | Enable for the current array |
| out_mode_o | output | 2 | 00 drive, 01 float, 10 ground |
| code_o | output | CODE_W | Held code |
| ready_o | output | 1 | Output valid |

## Verification
Code capture and a mode exit can fall on the same edge. When the converter is ready and the pins request standby or shutdown, that edge still captures the code present on `code_i`, because ready is only dropped after the edge. The bench provokes this by changing the code and the pins together while ready is high. It then checks that this last code is what `code_o` shows during sleep and after wake-up, and that a different code presented during wake-up is not loaded.

// File: rtl/cvt_pwr_pkg.sv
package cvt_pwr_pkg;
  typedef enum logic [1:0] {
    PM_SHUT = 2'd0,
    PM_STBY = 2'd1,
    PM_RUN  = 2'd2
  } pwr_mode_e;

  localparam logic [1:0] OM_DRIVE = 2'b00;
  localparam logic [1:0] OM_FLOAT = 2'b01;
  localparam logic [1:0] OM_GND   = 2'b10;

  // pin decode: power-down dominates, enable chooses between run and standby
  function automatic pwr_mode_e decode_mode(input logic pd, input logic en);
    if (pd) return PM_SHUT;
    else if (en) return PM_RUN;
    else return PM_STBY;
  endfunction

  // settle length for a transition into 'nxt' coming from 'prv'
  function automatic int unsigned settle_len(input pwr_mode_e prv, input pwr_mode_e nxt,
                                             input int unsigned shut_cyc,
                                             input int unsigned stby_cyc);
    if (nxt != PM_RUN) return 0;
    else if (prv == PM_SHUT) return shut_cyc;
    else return stby_cyc;
  endfunction
endpackage

// File: rtl/cvt_mode_reg.sv
module cvt_mode_reg
  import cvt_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_i,
  input  logic      en_i,
  output pwr_mode_e mode_o,
  output pwr_mode_e mode_nxt_o,
  output logic      change_o
);
  pwr_mode_e mode_q;

  assign mode_nxt_o = decode_mode(pd_i, en_i);
  assign change_o   = (mode_nxt_o != mode_q);
  assign mode_o     = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_SHUT;
    else        mode_q <= mode_nxt_o;
  end

  // R1
  shut_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> (mode_q == PM_SHUT));
  // R8
  no_change_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !change_o |=> $stable(mode_q));
endmodule

// File: rtl/cvt_settle_timer.sv
module cvt_settle_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R8
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && busy_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cvt_code_hold.sv
module cvt_code_hold #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (cap_i) code_q <= code_i;
  end

  assign code_o = code_q;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(code_q));
  // R9
  capture_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (code_q == $past(code_i)));
endmodule

// File: rtl/cvt_pwr_ctrl.sv
module cvt_pwr_ctrl
  import cvt_pwr_pkg::*;
#(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SHUT_CYC   = 20,
  parameter int unsigned STBY_CYC   = 4,
  parameter bit          OFF_GROUND = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ref_en_o,
  output logic              array_en_o,
  output logic [1:0]        out_mode_o,
  output logic [CODE_W-1:0] code_o,
  output logic              ready_o
);
  localparam int unsigned MAX_CYC = (SHUT_CYC > STBY_CYC) ? SHUT_CYC : STBY_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
  localparam logic [1:0]  OFF_OM  = OFF_GROUND ? OM_GND : OM_FLOAT;

  pwr_mode_e        mode_w, mode_nxt_w;
  logic             change_w, busy_w, capture_w;
  logic [CNT_W-1:0] load_val_w;

  cvt_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_i       (pd_i),
    .en_i       (en_i),
    .mode_o     (mode_w),
    .mode_nxt_o (mode_nxt_w),
    .change_o   (change_w)
  );

  assign load_val_w = CNT_W'(settle_len(mode_w, mode_nxt_w, SHUT_CYC, STBY_CYC));

  cvt_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (change_w),
    .load_val_i (load_val_w),
    .busy_o     (busy_w)
  );

  assign ready_o    = (mode_w == PM_RUN) && !busy_w;
  assign capture_w  = ready_o;
  assign ref_en_o   = (mode_w != PM_SHUT);
  assign array_en_o = (mode_w == PM_RUN);
  assign out_mode_o = (mode_w == PM_RUN) ? OM_DRIVE : OFF_OM;

  cvt_code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (capture_w),
    .code_i (code_i),
    .code_o (code_o)
  );

  // R1
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> (!ref_en_o && !array_en_o && !ready_o));
  // R2
  standby_ref_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_i && !en_i) |=> (ref_en_o && !array_en_o && !ready_o));
  // R3
  run_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_i && en_i) |=> (array_en_o && ref_en_o && out_mode_o == OM_DRIVE));
  // R4
  off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !array_en_o |-> (out_mode_o == OFF_OM));
  // R7
  wake_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (change_w && mode_nxt_w == PM_RUN && load_val_w != 0) |=> !ready_o);
endmodule

// File: tb/cvt_pwr_ctrl_test.sv
module cvt_pwr_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd = 1'b1, en = 1'b0;
  logic [7:0] code = 8'h00;
  logic       ref_en, arr_en, rdy;
  logic [1:0] om;
  logic [7:0] cout;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cvt_pwr_ctrl #(.CODE_W(8), .SHUT_CYC(20), .STBY_CYC(4), .OFF_GROUND(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .pd_i(pd), .en_i(en), .code_i(code),
    .ref_en_o(ref_en), .array_en_o(arr_en), .out_mode_o(om),
    .code_o(cout), .ready_o(rdy)
  );

  // fields: pd en code[8] cycles[8] ref arr mode[2] rdy exp_code[8]
  localparam int NV = 24;
  localparam logic [30:0] TBL [0:NV-1] = '{
    {1'b0,1'b1,8'h5A,8'd1 ,1'b1,1'b1,2'b00,1'b0,8'h00}, // R3 R5 leave shutdown
    {1'b0,1'b1,8'h5A,8'd19,1'b1,1'b1,2'b00,1'b0,8'h00}, // R6 still settling at 20
    {1'b0,1'b1,8'h5A,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h00}, // R6 ready after 20
    {1'b0,1'b1,8'h5A,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h5A}, // R9 first capture
    {1'b0,1'b1,8'h3C,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h3C}, // R9
    {1'b0,1'b0,8'h77,8'd1 ,1'b1,1'b0,2'b01,1'b0,8'h77}, // R2 R4 same-edge capture
    {1'b0,1'b0,8'h11,8'd3 ,1'b1,1'b0,2'b01,1'b0,8'h77}, // R9 hold in standby
    {1'b0,1'b1,8'h22,8'd4 ,1'b1,1'b1,2'b00,1'b0,8'h77}, // R7 settling
    {1'b0,1'b1,8'h22,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h77}, // R7 ready, last code
    {1'b0,1'b1,8'h22,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h22}, // R9
    {1'b1,1'b1,8'h99,8'd1 ,1'b0,1'b0,2'b01,1'b0,8'h99}, // R1 R4 same-edge capture
    {1'b1,1'b0,8'h44,8'd5 ,1'b0,1'b0,2'b01,1'b0,8'h99}, // R1 R8 enable ignored
    {1'b0,1'b0,8'h44,8'd2 ,1'b1,1'b0,2'b01,1'b0,8'h99}, // R2
    {1'b0,1'b1,8'h44,8'd4 ,1'b1,1'b1,2'b00,1'b0,8'h99}, // R7 R8 path from standby
    {1'b0,1'b1,8'h44,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h99}, // R7
    {1'b0,1'b1,8'h44,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h44}, // R9
    {1'b0,1'b0,8'h44,8'd1 ,1'b1,1'b0,2'b01,1'b0,8'h44}, // R2
    {1'b0,1'b1,8'h44,8'd2 ,1'b1,1'b1,2'b00,1'b0,8'h44}, // R8 interrupted wake
    {1'b0,1'b0,8'h44,8'd1 ,1'b1,1'b0,2'b01,1'b0,8'h44}, // R8
    {1'b0,1'b1,8'h44,8'd4 ,1'b1,1'b1,2'b00,1'b0,8'h44}, // R8 full restart
    {1'b0,1'b1,8'h44,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h44}, // R8
    {1'b1,1'b0,8'h44,8'd1 ,1'b0,1'b0,2'b01,1'b0,8'h44}, // R1
    {1'b0,1'b1,8'h44,8'd20,1'b1,1'b1,2'b00,1'b0,8'h44}, // R6 R8 long path
    {1'b0,1'b1,8'h44,8'd1 ,1'b1,1'b1,2'b00,1'b1,8'h44}  // R6
  };

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic check_all(input int row, input logic r, input logic a,
                           input logic [1:0] m, input logic y, input logic [7:0] c);
    check($sformatf("row %0d ref_en (R1 R2 R3 R5)", row), {7'd0, ref_en}, {7'd0, r});
    check($sformatf("row %0d array_en (R1 R2 R3)", row), {7'd0, arr_en}, {7'd0, a});
    check($sformatf("row %0d out_mode (R4)", row), {6'd0, om}, {6'd0, m});
    check($sformatf("row %0d ready (R6 R7 R8)", row), {7'd0, rdy}, {7'd0, y});
    check($sformatf("row %0d code (R9)", row), cout, c);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_all(-1, 1'b0, 1'b0, 2'b01, 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(-2, 1'b0, 1'b0, 2'b01, 1'b0, 8'h00);
    for (int i = 0; i < NV; i++) begin
      pd   = TBL[i][30];
      en   = TBL[i][29];
      code = TBL[i][28:21];
      repeat (int'(TBL[i][20:13])) @(negedge clk);
      check_all(i, TBL[i][12], TBL[i][11], TBL[i][10:9], TBL[i][8], TBL[i][7:0]);
    end
    // R10 reset in the middle of run
    code = 8'hE1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_all(100, 1'b0, 1'b0, 2'b01, 1'b0, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 after reset the shutdown delay applies again
    check_all(101, 1'b1, 1'b1, 2'b00, 1'b0, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule